// File: doc/BRIEF.md
# Two-Wire Clock-Enable Control Slave

This block is a slave on a two-wire serial bus. A master uses it to switch individual clock outputs on or off: each bit of a small bank of 8-bit control registers enables one output. The block runs on a fast system clock. It passes both bus lines through a two-flop synchronizer and finds bus events by comparing successive samples.

A write transfer has a fixed layout. The address byte comes first. Two filler bytes follow, which are acknowledged and then discarded. Every byte after that lands in register 0, register 1 and onward until the stop condition, so the bus carries no register index. A read transfer returns the bank from register 0 upward for as long as the master keeps acknowledging.

The register bank is presented in parallel to the clock gating logic. Only the power-up reset restores the defaults.

Top module: `ctl_2w_slave`

## Requirements
- R1: After reset every control register holds 0xFF, so `ctl_bank_o` reads all ones, and the block does not pull the data line.
- R2: An address byte whose upper 7 bits are 1101001 is acknowledged by pulling the data line low during the ninth clock. On any other address the block stays silent and acknowledges nothing until the next start condition.
- R3: In a write (address bit 0 = 0), the two bytes after the address are acknowledged and their values are discarded.
- R4: Each later data byte is acknowledged and stored in order into register 0, 1, 2, 3. Register i appears on `ctl_bank_o[8i+7:8i]`, and bytes travel MSB first.
- R5: Data bytes sent after the last register has been written are acknowledged and dropped.
- R6: A stop condition ends the transfer, and the next write again starts filling at register 0.
- R7: With address byte 0xD3 (read), the block acknowledges and then sends register 0, 1, 2, 3, MSB first. It sends one byte after each master acknowledge, and 0x00 once past the last register.
- R8: When the master does not acknowledge a read byte, the block releases the data line and drives nothing until a new start condition.
- R9: A start condition in the middle of a transfer restarts address reception. The byte count of the interrupted transfer is discarded.
- R10: Register contents survive stop conditions, reads and mismatched addresses. Only reset brings back 0xFF.
- R11: The block changes its data-line pull only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |
| ctl_bank_o | output | NREG*8 | Control registers, register i in bits 8i+7:8i |

## Verification
A wrong phase count or state shows up within one byte. A filler byte lands in a register, or an acknowledge appears where none should, or goes missing, in the ninth clock of the byte that went wrong. A wrong write index or a wrong read index becomes visible on `ctl_bank_o` right after the stop condition, or in the read data at the latest. A pull left asserted after a master NACK shows on the wire as 0 bits in the very next byte the master clocks.

// File: rtl/ctl_2w_slave.sv
module ctl_2w_slave #(
  parameter int          NREG     = 4,
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  parameter logic [7:0]  PWR_VAL  = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [NREG*8-1:0] ctl_bank_o
);
  localparam int PW = $clog2(NREG + 1);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_IGN} st_t;

  st_t          st;
  logic [1:0]   scl_m, sda_m;
  logic         scl_q, sda_q, scl_s, sda_s;
  logic         start_c, stop_c, rise, fall;
  logic [7:0]   sr, txsh;
  logic [2:0]   bcnt;
  logic [1:0]   ph;
  logic         done, rw, mack, pull;
  logic [PW-1:0] ptr, nptr;
  logic [7:0]   nval;
  logic [7:0]   regs [NREG];

  assign scl_s   = scl_m[1];
  assign sda_s   = sda_m[1];
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign nptr    = (ptr < PW'(NREG)) ? ptr + 1'b1 : ptr;
  assign nval    = (nptr < PW'(NREG)) ? regs[nptr[AW-1:0]] : 8'h00;
  assign sda_pull_o = pull;

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    assign ctl_bank_o[8*i +: 8] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i}; sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_m[1];          sda_q <= sda_m[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sr <= '0; txsh <= '0; bcnt <= '0; ph <= '0;
      done <= 1'b0; rw <= 1'b0; mack <= 1'b0; pull <= 1'b0; ptr <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= PWR_VAL;
    end else if (start_c) begin
      st <= S_RX; ph <= 2'd0; bcnt <= '0; done <= 1'b0; ptr <= '0; pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; pull <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (rise && !done) begin
            sr   <= {sr[6:0], sda_s};
            bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) done <= 1'b1;
          end else if (fall && done) begin
            done <= 1'b0;
            bcnt <= '0;
            if (ph == 2'd0 && sr[7:1] != DEV_ADDR) begin
              st <= S_IGN;
            end else begin
              st   <= S_ACK;
              pull <= 1'b1;
              if (ph == 2'd0) rw <= sr[0];
              if (ph == 2'd3 && ptr < PW'(NREG)) begin
                regs[ptr[AW-1:0]] <= sr;
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        S_ACK: if (fall) begin
          if (ph == 2'd0 && rw) begin
            st   <= S_TX;
            txsh <= regs[0];
            pull <= ~regs[0][7];
          end else begin
            st   <= S_RX;
            pull <= 1'b0;
            if (ph != 2'd3) ph <= ph + 1'b1;
          end
        end
        S_TX: if (fall) begin
          if (bcnt == 3'd7) begin
            st <= S_MACK; pull <= 1'b0; bcnt <= '0;
          end else begin
            txsh <= {txsh[6:0], 1'b0};
            pull <= ~txsh[6];
            bcnt <= bcnt + 1'b1;
          end
        end
        S_MACK: begin
          if (rise) mack <= ~sda_s;
          else if (fall) begin
            if (mack) begin
              st <= S_TX; ptr <= nptr; txsh <= nval; pull <= ~nval[7];
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);
  p_silent_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN || st == S_IDLE) |-> !sda_pull_o);
  p_bank_data_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bank_o != $past(ctl_bank_o)) |-> (st == S_ACK && ph == 2'd3));
  p_ptr_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NREG));
  p_tx_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> rw);
endmodule

// File: tb/tb_ctl_2w_slave.sv
module tb_ctl_2w_slave;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [31:0] bank;
  wire  sda_line = sda_m & ~sda_pull;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ctl_2w_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                    .sda_pull_o(sda_pull), .ctl_bank_o(bank));

  typedef struct packed {
    logic [7:0]  adr;
    logic [31:0] dat;
    logic [2:0]  n;
    logic        ack;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hD2, 32'h11223344, 3'd4, 1'b1, 32'h44332211},
    '{8'hD2, 32'hA55A0000, 3'd2, 1'b1, 32'h44335AA5},
    '{8'hD4, 32'h00000000, 3'd2, 1'b0, 32'h44335AA5},
    '{8'hD2, 32'h0F000000, 3'd1, 1'b1, 32'h44335A0F},
    '{8'h52, 32'hFFFFFFFF, 3'd4, 1'b0, 32'h44335A0F},
    '{8'hD2, 32'h00000000, 3'd0, 1'b1, 32'h44335A0F}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; qw(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; qw(); sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = ~sda_line; qw();
    a2 = ~sda_line;
    chk(ack == a2, "R11 pull steady while clock high", {31'd0, a2}, {31'd0, ack});
    scl_m = 1'b0; qw();
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl_m = 1'b1; qw(); b = {b[6:0], sda_line}; qw(); scl_m = 1'b0; qw();
    end
    sda_m = ~mack; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    logic [7:0] rexp [5] = '{8'h0F, 8'h5A, 8'h33, 8'h44, 8'h00};
    repeat (5) @(negedge clk);
    chk(bank == 32'hFFFFFFFF, "R1 bank in reset", bank, 32'hFFFFFFFF);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(bank == 32'hFFFFFFFF, "R1 bank after reset", bank, 32'hFFFFFFFF);
    chk(sda_pull == 1'b0, "R1 no pull", {31'd0, sda_pull}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(VEC[v].adr, a);
      chk(a == VEC[v].ack, "R2 address ack", {31'd0, a}, {31'd0, VEC[v].ack});
      send_byte(8'hAA, a);
      chk(a == VEC[v].ack, "R3 command byte ack", {31'd0, a}, {31'd0, VEC[v].ack});
      send_byte(8'h55, a);
      chk(a == VEC[v].ack, "R3 count byte ack", {31'd0, a}, {31'd0, VEC[v].ack});
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        send_byte(VEC[v].dat[31 - 8*k -: 8], a);
        chk(a == VEC[v].ack, "R4 data ack", {31'd0, a}, {31'd0, VEC[v].ack});
      end
      bus_stop();
      chk(bank == VEC[v].exp, "R4/R6 bank after write", bank, VEC[v].exp);
    end

    bus_start();
    send_byte(8'hD3, a);
    chk(a == 1'b1, "R7 read address ack", {31'd0, a}, 32'd1);
    for (int k = 0; k < 5; k++) begin
      read_byte(k < 4, rb);
      chk(rb == rexp[k], "R7 read data", {24'd0, rb}, {24'd0, rexp[k]});
    end
    read_byte(1'b0, rb);
    chk(rb == 8'hFF, "R8 line released after NACK", {24'd0, rb}, 32'hFF);
    bus_stop();
    chk(bank == 32'h44335A0F, "R10 bank kept across read", bank, 32'h44335A0F);

    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    for (int k = 1; k <= 6; k++) begin
      send_byte(8'(k), a);
      chk(a == 1'b1, "R5 extra bytes acked", {31'd0, a}, 32'd1);
    end
    bus_stop();
    chk(bank == 32'h04030201, "R5 extra bytes dropped", bank, 32'h04030201);

    bus_start();
    send_byte(8'hD2, a); send_byte(8'hAA, a);
    bus_start();
    send_byte(8'hD2, a);
    chk(a == 1'b1, "R9 address after repeated start", {31'd0, a}, 32'd1);
    send_byte(8'hAA, a); send_byte(8'h55, a); send_byte(8'h77, a);
    bus_stop();
    chk(bank == 32'h04030277, "R9 restart realigns bytes", bank, 32'h04030277);

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bank == 32'hFFFFFFFF, "R10 reset restores defaults", bank, 32'hFFFFFFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule